// File: doc/BRIEF.md
# Block-Parallel First-Order Recursive Filter

This block evaluates the recursion y(n) = a·y(n−w) + x(n) on several samples per clock. The serial one-sample-per-step data-flow graph is unfolded by a factor J: the block holds J copies of the multiply-add node, one per lane. Each clock with valid data it accepts J consecutive input samples and returns the J matching output samples, so it delivers J times the sample rate of the serial form.

The lanes are not independent filters. Lane k's feedback comes from lane (k − w) mod J. The number of registers on that edge is floor((src + w) / J), where src is the source lane. Summed over all lanes, these counts equal w, the delay of the serial loop. When w < J, some edges have no register, and those lanes form a combinational chain in increasing lane order inside one clock. The lane count, the loop delay, the data and coefficient widths, the fraction bits and the coefficient are all parameters.

Top module: `unf_iir_par`

## Requirements
- R1: Lane k (bits [k·DW +: DW] of both `x_lanes` and `y_lanes`) carries sample index n = m·LANES + k in the m-th valid cycle. Lane 0 holds the oldest sample of each group, and the output sequence matches the serial recursion sample for sample.
- R2: When LOOP_DLY > LANES, a lane's feedback can pass through more than one register, and the outputs still equal the serial recursion.
- R3: When LOOP_DLY < LANES, lane k ≥ LOOP_DLY takes its feedback from lane k − LOOP_DLY in the same cycle, without a register. In particular, whenever lane 0's output is zero, lane LOOP_DLY's output equals its input.
- R4: Each output is x + floor(a·y(n−w) + 1/2), where a = COEF / 2^FRAC. The product is kept at full precision, and a result exactly halfway between two integers rounds toward +∞. For example, with a = 0.5, y = 175 gives +88 and y = −85 gives −42.
- R5: A result above 2^(DW−1)−1 or below −2^(DW−1) is clamped to that limit.
- R6: A synchronous reset clears every feedback register to zero. In the first valid cycle after reset, the outputs equal the serial recursion with y(n) = 0 for n < 0, so the first LOOP_DLY outputs equal their inputs.
- R7: While `in_valid` is low, no feedback register changes. The input samples presented during such cycles are discarded, and the filter resumes from the state it had before.
- R8: `out_valid` equals `in_valid` in the same cycle, and the outputs belong to the inputs of that same cycle, with no pipeline latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears the loop registers |
| in_valid | input | 1 | A group of LANES samples is present and the state advances |
| x_lanes | input | LANES·DW | Input samples, lane k at bits [k·DW +: DW], two's complement |
| out_valid | output | 1 | The outputs are valid for this group |
| y_lanes | output | LANES·DW | Output samples, lane k at bits [k·DW +: DW], two's complement |

## Verification
The assertions assume that `x_lanes` is stable across each sampling edge. The state-hold property further assumes that an idle cycle is followed by inputs equal to the idle ones before it compares the outputs. The lane-chain property relies on every input sample being a legal DW-bit value, so that adding zero feedback cannot saturate. The stimulus changes inputs only on the falling edge and holds reset from time zero. Idle cycles use fresh random samples, which the model must never absorb, and the bench keeps three lane/delay configurations (w < J, w > J, w = 1 with a negative coefficient) in step against a one-sample-per-step reference.

// File: rtl/unf_pkg.sv
package unf_pkg;

   // Lane that feeds the loop input of lane dst after unfolding by j
   function automatic int fb_src_lane(input int dst, input int w, input int j);
      return (dst + j - (w % j)) % j;
   endfunction

   // Registers on the unfolded edge leaving lane src
   function automatic int edge_regs(input int src, input int w, input int j);
      return (src + w) / j;
   endfunction

   // Sum of registers over every unfolded loop edge
   function automatic int loop_regs_total(input int w, input int j);
      int t;
      t = 0;
      for (int i = 0; i < j; i++) t += edge_regs(i, w, j);
      return t;
   endfunction

endpackage

// File: rtl/unf_delay_line.sv
module unf_delay_line #(
   parameter int DW    = 16,
   parameter int DEPTH = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   logic [DW-1:0] stage [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else if (en) begin
         stage[0] <= d;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[DEPTH-1];

endmodule

// File: rtl/unf_mac.sv
module unf_mac #(
   parameter int                     DW   = 16,
   parameter int                     CW   = 16,
   parameter int                     FRAC = 14,
   parameter logic signed [CW-1:0]   COEF = 16'sd8192
) (
   input  logic signed [DW-1:0] x_in,
   input  logic signed [DW-1:0] fb_in,
   output logic signed [DW-1:0] y_out
);

   localparam int AW = DW + CW + 2;
   localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] MINV = ~MAXV;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);

   logic signed [AW-1:0] fb_e, coef_e, x_e;
   logic signed [AW-1:0] prod, acc, q;

   always_comb begin
      fb_e   = AW'(fb_in);
      coef_e = AW'(COEF);
      x_e    = AW'(x_in);
      prod   = fb_e * coef_e;
      acc    = prod + (x_e <<< FRAC) + HALF;
      q      = acc >>> FRAC;
      if (q > MAXV)      y_out = MAXV[DW-1:0];
      else if (q < MINV) y_out = MINV[DW-1:0];
      else               y_out = q[DW-1:0];
   end

endmodule

// File: rtl/unf_iir_par.sv
module unf_iir_par #(
   parameter int                   LANES    = 4,
   parameter int                   LOOP_DLY = 2,
   parameter int                   DW       = 16,
   parameter int                   CW       = 16,
   parameter int                   FRAC     = 14,
   parameter logic signed [CW-1:0] COEF     = 16'sd8192
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [LANES*DW-1:0]   x_lanes,
   output logic                  out_valid,
   output logic [LANES*DW-1:0]   y_lanes
);

   localparam int TOTAL_REGS = unf_pkg::loop_regs_total(LOOP_DLY, LANES);

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LOOP_DLY < 1) begin : g_bad_dly
      $error("LOOP_DLY must be at least 1");
   end
   if (DW < 2 || DW > 31) begin : g_bad_dw
      $error("DW must lie in 2..31");
   end
   if (FRAC < 1 || FRAC >= CW) begin : g_bad_frac
      $error("FRAC must lie in 1..CW-1");
   end
   if (TOTAL_REGS != LOOP_DLY) begin : g_bad_total
      $error("unfolded loop register count differs from LOOP_DLY");
   end

   logic signed [DW-1:0] node_y [LANES];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int SRC  = unf_pkg::fb_src_lane(k, LOOP_DLY, LANES);
      localparam int REGS = unf_pkg::edge_regs(SRC, LOOP_DLY, LANES);

      logic signed [DW-1:0] fb;

      if (REGS == 0) begin : g_wire
         // same-cycle edge: SRC < k, so the chain runs in lane order
         assign fb = node_y[SRC];
      end else begin : g_reg
         unf_delay_line #(
            .DW    (DW),
            .DEPTH (REGS)
         ) u_dl (
            .clk (clk),
            .rst (rst),
            .en  (in_valid),
            .d   (node_y[SRC]),
            .q   (fb)
         );
      end

      unf_mac #(
         .DW   (DW),
         .CW   (CW),
         .FRAC (FRAC),
         .COEF (COEF)
      ) u_mac (
         .x_in  (x_lanes[k*DW +: DW]),
         .fb_in (fb),
         .y_out (node_y[k])
      );

      assign y_lanes[k*DW +: DW] = node_y[k];
   end

   assign out_valid = in_valid;

endmodule

// File: rtl/unf_iir_chk.sv
module unf_iir_chk #(
   parameter int LANES    = 4,
   parameter int LOOP_DLY = 2,
   parameter int DW       = 16
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [LANES*DW-1:0] x_lanes,
   input logic                out_valid,
   input logic [LANES*DW-1:0] y_lanes
);

   // R7
   hold_state_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!in_valid) && !$past(rst) && $stable(x_lanes)) |-> $stable(y_lanes));

   // R8
   out_valid_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid);

   // R6
   reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && in_valid) |-> (y_lanes[DW-1:0] == x_lanes[DW-1:0]));

   if (LOOP_DLY < LANES) begin : g_chain
      // R3
      chain_chk: assert property (@(posedge clk) disable iff (rst)
         (y_lanes[DW-1:0] == '0) |->
            (y_lanes[LOOP_DLY*DW +: DW] == x_lanes[LOOP_DLY*DW +: DW]));
   end

endmodule

bind unf_iir_par unf_iir_chk #(
   .LANES    (LANES),
   .LOOP_DLY (LOOP_DLY),
   .DW       (DW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .x_lanes   (x_lanes),
   .out_valid (out_valid),
   .y_lanes   (y_lanes)
);

// File: tb/unf_iir_par_bench.sv
module unf_iir_par_bench;

   localparam int PER = 10;
   localparam int NI  = 3;
   localparam int JJ [NI] = '{4, 3, 2};
   localparam int WW [NI] = '{2, 5, 1};
   localparam int CC [NI] = '{8192, 12288, -10240};

   // hand-worked group values for instance 0 (a = 0.5, w = 2, 4 lanes)
   localparam logic signed [15:0] TAB_X [16] = '{
      16'sd100, 16'sd200, 16'sd300, 16'sd400,
      16'sd0,   16'sd0,   16'sd0,   16'sd0,
      -16'sd3,  -16'sd1,  16'sd7,   16'sd0,
      -16'sd100,-16'sd101,16'sd0,   16'sd0};
   localparam logic signed [15:0] TAB_Y [16] = '{
      16'sd100, 16'sd200, 16'sd350, 16'sd500,
      16'sd175, 16'sd250, 16'sd88,  16'sd125,
      16'sd41,  16'sd62,  16'sd28,  16'sd31,
      -16'sd86, -16'sd85, -16'sd43, -16'sd42};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        vld = 1'b0;
   logic [63:0] xv [NI];
   logic [63:0] ya;
   logic [47:0] yb;
   logic [31:0] yc;
   logic        ova, ovb, ovc;

   int          hy [NI][2048];
   int          cnt [NI];
   int          n_tests = 0;
   int          n_fail  = 0;
   logic [31:0] seed    = 32'h1234_5678;

   always #(PER/2) clk = ~clk;

   unf_iir_par u_unf_iir_par (
      .clk (clk), .rst (rst), .in_valid (vld),
      .x_lanes (xv[0][63:0]), .out_valid (ova), .y_lanes (ya));

   unf_iir_par #(.LANES(3), .LOOP_DLY(5), .COEF(16'sd12288)) u_unf_iir_par_b (
      .clk (clk), .rst (rst), .in_valid (vld),
      .x_lanes (xv[1][47:0]), .out_valid (ovb), .y_lanes (yb));

   unf_iir_par #(.LANES(2), .LOOP_DLY(1), .COEF(-16'sd10240)) u_unf_iir_par_c (
      .clk (clk), .rst (rst), .in_valid (vld),
      .x_lanes (xv[2][31:0]), .out_valid (ovc), .y_lanes (yc));

   function automatic logic [63:0] out_of(input int g);
      case (g)
         0:       return ya;
         1:       return {16'h0, yb};
         default: return {32'h0, yc};
      endcase
   endfunction

   function automatic logic valid_of(input int g);
      case (g)
         0:       return ova;
         1:       return ovb;
         default: return ovc;
      endcase
   endfunction

   function automatic int ref_step(input int x, input int yp, input int c);
      longint acc, q;
      acc = longint'(yp) * c + (longint'(x) <<< 14) + (longint'(1) <<< 13);
      q   = acc >>> 14;
      if (q > 32767)  q = 32767;
      if (q < -32768) q = -32768;
      return int'(q);
   endfunction

   function automatic int gen(input int mode);
      case (mode)
         1: return 32000;
         2: return -32000;
         3: return 0;
         default: begin
            seed = seed * 32'd1103515245 + 32'd12345;
            return int'((seed >> 16) % 32'd4001) - 2000;
         end
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int g,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s inst%0d: actual %h expected %h", req, g, act, exp);
      end
   endtask

   task automatic step(input bit v, input int mode, input bit tab,
                       input int row, input string req);
      logic [63:0] ex [NI];
      @(negedge clk);
      vld = v;
      for (int g = 0; g < NI; g++) begin
         ex[g] = '0;
         for (int k = 0; k < JJ[g]; k++) begin
            int s;
            s = (tab && g == 0) ? int'(TAB_X[row*4 + k]) : gen(mode);
            xv[g][k*16 +: 16] = 16'(s);
            if (v) begin
               int n, yp, e;
               n  = cnt[g];
               yp = (n >= WW[g]) ? hy[g][n - WW[g]] : 0;
               e  = ref_step(s, yp, CC[g]);
               hy[g][n] = e;
               cnt[g]   = n + 1;
               ex[g][k*16 +: 16] = 16'(e);
            end
         end
      end
      #(PER/4);
      for (int g = 0; g < NI; g++) begin
         // R8: valid passes straight through
         check(valid_of(g) == v, "R8", g, 64'(valid_of(g)), 64'(v));
         if (v) check(out_of(g) == ex[g], req, g, out_of(g), ex[g]);
      end
      if (tab) begin
         logic [63:0] te;
         for (int k = 0; k < 4; k++) te[k*16 +: 16] = TAB_Y[row*4 + k];
         // R4: hand-rounded values, including negative halves
         check(ya == te, "R4", 0, ya, te);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      vld = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int g = 0; g < NI; g++) cnt[g] = 0;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(PER * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int g = 0; g < NI; g++) begin
         xv[g]  = '0;
         cnt[g] = 0;
      end
      do_reset();
      // R1 / R3 / R4: hand table walked group by group
      for (int r = 0; r < 4; r++) step(1'b1, 0, 1'b1, r, "R1");
      // R1 / R2 / R3: general stimulus across all three lane/delay mixes
      repeat (40) step(1'b1, 0, 1'b0, 0, "R2");
      // R7: idle cycles with changing data, then resume
      repeat (5)  step(1'b0, 0, 1'b0, 0, "R7");
      repeat (20) step(1'b1, 0, 1'b0, 0, "R7");
      // R5: drive towards both saturation limits
      repeat (30) step(1'b1, 1, 1'b0, 0, "R5");
      repeat (30) step(1'b1, 2, 1'b0, 0, "R5");
      // R6: mid-run reset, zero group then live data from cleared state
      do_reset();
      step(1'b1, 3, 1'b0, 0, "R6");
      do_reset();
      repeat (3)  step(1'b1, 0, 1'b0, 0, "R6");
      repeat (60) step(1'b1, 0, 1'b0, 0, "R3");
      finish_run();
   end

endmodule